// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A packed 8-bit mode byte sets the frame shape at run time: 5 to 8 data bits, an optional odd or even parity bit, a stop length of 1, 1.5 or 2 bit times, and a bit time of 1, 16 or 64 clock cycles. Software loads a byte into a one-entry holding register. The block moves the byte into its shifter as soon as the shifter is free and transmission is enabled.

Two status outputs report progress. `hold_empty` shows that the holding register can take another byte. `shifter_idle` shows that no frame is on the line. A break input pulls the line low without disturbing frame timing. The frame format is captured when each byte moves into the shifter, so a new mode byte written during a frame takes effect from the next frame onward.

Top module: `async_tx_engine`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `shifter_idle` is 1. The mode byte resets to 0x00, which selects 1 cycle per bit, 5 data bits, no parity and 1 stop bit.
- R2: Mode bits [1:0] set the bit time: 10 gives 16 cycles, 11 gives 64 cycles, and 01 or 00 gives 1 cycle.
- R3: Mode bits [3:2] set the data length: 00, 01, 10 and 11 give 5, 6, 7 and 8 bits. Data bits go out LSB first, and byte bits above the length are not sent.
- R4: Mode bit 4 enables a parity bit after the data. Mode bit 5 set gives even parity and clear gives odd parity. Parity covers only the data bits that are sent.
- R5: Mode bits [7:6] set the stop length: 11 gives 2 bit times, 10 gives 1.5 bit times (rounded up to 2 cycles when a bit time is 1 cycle), and 01 or 00 gives 1 bit time.
- R6: A frame is a low start bit, then the data bits, then the optional parity bit, then high stop bits. Each element lasts one bit time. `txd` is high whenever no frame is in progress.
- R7: A `hold_wr` captured while the holding register is empty makes `hold_empty` read 0 from the next cycle. `hold_empty` returns to 1 in the same cycle that the byte moves to the shifter. A `hold_wr` while the register is full is ignored.
- R8: When the shifter is idle, a byte is held and `tx_enable` is 1, the byte loads at the next clock edge and the start bit appears on `txd` from that edge. If a byte is waiting when the last stop cycle ends, its start bit follows directly with no idle cycle between frames.
- R9: While `tx_enable` is 0, no byte is loaded and a held byte stays held. A frame already in progress still completes.
- R10: While `brk` is 1, `txd` is 0 in the same cycle, whatever the shifter state. Frame timing goes on unchanged.
- R11: `shifter_idle` is 0 for exactly the duration of each frame and 1 otherwise.
- R12: The frame format is taken from the mode byte at the moment the byte loads. A `mode_wr` during a frame changes only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-time tick source |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Writes `mode_byte` into the mode register |
| mode_byte | input | 8 | Packed frame format (rate, length, parity, stop) |
| tx_enable | input | 1 | Allows held bytes to start transmission |
| brk | input | 1 | Forces `txd` low |
| hold_wr | input | 1 | Writes `hold_data` into the holding register |
| hold_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| shifter_idle | output | 1 | No frame in progress |

## Verification
Each frame is compared cycle by cycle against a waveform built from the mode byte and the data. A wrong bit counter, element counter or format snapshot therefore shows as a `txd` mismatch inside the same frame, or as `shifter_idle` rising a cycle early or late. A bad holding-register state shows within one cycle as a wrong `hold_empty`. It also shows as a missing or extra frame after the current one ends. Back-to-back frames and a mode write during a frame test the hand-off from the end of the stop bits to the next load.

// File: rtl/atx_pkg.sv
package atx_pkg;

    localparam int BYTE_W   = 8;
    localparam int MIN_BITS = 5;
    localparam int MID_DIV  = 16;
    localparam int SLOW_DIV = 64;
    localparam int CNT_W    = $clog2(2 * SLOW_DIV);
    localparam int IDX_W    = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    // Per-frame format, counts stored minus one
    typedef struct packed {
        logic [CNT_W-1:0] bit_ticks;
        logic [CNT_W-1:0] stop_ticks;
        logic [IDX_W-1:0] last_idx;
        logic             par_en;
        logic             par_even;
    } frame_cfg_t;

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] shreg;
        logic              par_bit;
        frame_cfg_t        cfg;
    } shift_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } hold_t;

endpackage

// File: rtl/atx_mode_decode.sv
module atx_mode_decode
    import atx_pkg::*;
(
    input  logic [BYTE_W-1:0] mode_byte,
    output frame_cfg_t        cfg
);

    int div;
    int stop;

    always_comb begin
        case (mode_byte[1:0])
            2'b10:   div = MID_DIV;
            2'b11:   div = SLOW_DIV;
            default: div = 1;
        endcase

        case (mode_byte[7:6])
            2'b10:   stop = (3 * div + 1) / 2;
            2'b11:   stop = 2 * div;
            default: stop = div;
        endcase

        cfg.bit_ticks  = CNT_W'(div - 1);
        cfg.stop_ticks = CNT_W'(stop - 1);
        cfg.last_idx   = IDX_W'(MIN_BITS - 1 + int'(mode_byte[3:2]));
        cfg.par_en     = mode_byte[4];
        cfg.par_even   = mode_byte[5];
    end

endmodule

// File: rtl/atx_hold.sv
module atx_hold
    import atx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              take,
    output logic              valid,
    output logic [BYTE_W-1:0] data
);

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) begin
            h_d.valid = 1'b0;
        end else if (wr && !h_q.valid) begin
            h_d.valid = 1'b1;
            h_d.data  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign valid = h_q.valid;
    assign data  = h_q.data;

endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
    import atx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              brk,
    input  frame_cfg_t        cfg_in,
    input  logic              hold_valid,
    input  logic [BYTE_W-1:0] hold_byte,
    output logic              take,
    output logic              txd,
    output logic              idle
);

    shift_t s_d, s_q;
    logic   can_load;
    logic   line;

    function automatic shift_t begin_frame(frame_cfg_t c, logic [BYTE_W-1:0] b);
        shift_t            s;
        logic [BYTE_W-1:0] mask;
        for (int i = 0; i < BYTE_W; i++) begin
            mask[i] = (i <= int'(c.last_idx));
        end
        s.state   = ST_START;
        s.cnt     = c.bit_ticks;
        s.idx     = '0;
        s.shreg   = b;
        s.par_bit = (^(b & mask)) ^ ~c.par_even;
        s.cfg     = c;
        return s;
    endfunction

    assign can_load = tx_enable && hold_valid;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        if (s_q.state == ST_IDLE) begin
            if (can_load) begin
                s_d  = begin_frame(cfg_in, hold_byte);
                take = 1'b1;
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else begin
            case (s_q.state)
                ST_START: begin
                    s_d.state = ST_DATA;
                    s_d.cnt   = s_q.cfg.bit_ticks;
                end
                ST_DATA: begin
                    s_d.shreg = s_q.shreg >> 1;
                    if (s_q.idx == s_q.cfg.last_idx) begin
                        if (s_q.cfg.par_en) begin
                            s_d.state = ST_PAR;
                            s_d.cnt   = s_q.cfg.bit_ticks;
                        end else begin
                            s_d.state = ST_STOP;
                            s_d.cnt   = s_q.cfg.stop_ticks;
                        end
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.cnt = s_q.cfg.bit_ticks;
                    end
                end
                ST_PAR: begin
                    s_d.state = ST_STOP;
                    s_d.cnt   = s_q.cfg.stop_ticks;
                end
                ST_STOP: begin
                    if (can_load) begin
                        s_d  = begin_frame(cfg_in, hold_byte);
                        take = 1'b1;
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (s_q.state)
            ST_START: line = 1'b0;
            ST_DATA:  line = s_q.shreg[0];
            ST_PAR:   line = s_q.par_bit;
            default:  line = 1'b1;
        endcase
        txd = line & ~brk;
    end

    assign idle = (s_q.state == ST_IDLE);

endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
    import atx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [BYTE_W-1:0] mode_byte,
    input  logic              tx_enable,
    input  logic              brk,
    input  logic              hold_wr,
    input  logic [BYTE_W-1:0] hold_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              shifter_idle
);

    logic [BYTE_W-1:0] mode_d, mode_q;
    frame_cfg_t        cfg;
    logic              h_valid;
    logic [BYTE_W-1:0] h_data;
    logic              take;

    always_comb begin
        mode_d = mode_q;
        if (mode_wr) mode_d = mode_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    atx_mode_decode u_dec (
        .mode_byte (mode_q),
        .cfg       (cfg)
    );

    atx_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (hold_wr),
        .wdata (hold_data),
        .take  (take),
        .valid (h_valid),
        .data  (h_data)
    );

    atx_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_enable  (tx_enable),
        .brk        (brk),
        .cfg_in     (cfg),
        .hold_valid (h_valid),
        .hold_byte  (h_data),
        .take       (take),
        .txd        (txd),
        .idle       (shifter_idle)
    );

    assign hold_empty = ~h_valid;

endmodule

// File: rtl/atx_checker.sv
module atx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_enable,
    input logic brk,
    input logic hold_wr,
    input logic txd,
    input logic hold_empty,
    input logic shifter_idle
);

    // R6: line rests high between frames
    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shifter_idle && !brk) |-> txd);

    // R10: break wins over everything
    p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    // R7: leaving idle means the held byte was taken
    p_load_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shifter_idle) |-> hold_empty);

    // R8: a frame opens with the start bit
    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shifter_idle) && !brk) |-> !txd);

    // R9: no load while disabled
    p_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && shifter_idle) |=> shifter_idle);

    // R9: a held byte stays held while disabled
    p_keep_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !hold_empty) |=> !hold_empty);

    // R7: an empty register fills after a write
    p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_wr && hold_empty && !tx_enable) |=> !hold_empty);

endmodule

bind async_tx_engine atx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_enable    (tx_enable),
    .brk          (brk),
    .hold_wr      (hold_wr),
    .txd          (txd),
    .hold_empty   (hold_empty),
    .shifter_idle (shifter_idle)
);

// File: tb/async_tx_engine_bench.sv
module async_tx_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_byte = '0;
    logic       tx_enable = 1'b0;
    logic       brk = 1'b0;
    logic       hold_wr = 1'b0;
    logic [7:0] hold_data = '0;
    logic       txd, hold_empty, shifter_idle;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    async_tx_engine u_async_tx_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_byte    (mode_byte),
        .tx_enable    (tx_enable),
        .brk          (brk),
        .hold_wr      (hold_wr),
        .hold_data    (hold_data),
        .txd          (txd),
        .hold_empty   (hold_empty),
        .shifter_idle (shifter_idle)
    );

    function automatic int f_div(logic [7:0] m);
        if (m[1:0] == 2'b10) return 16;
        if (m[1:0] == 2'b11) return 64;
        return 1;
    endfunction

    function automatic int f_len(logic [7:0] m);
        return 5 + int'(m[3:2]);
    endfunction

    function automatic int f_stop(logic [7:0] m);
        int d = f_div(m);
        if (m[7:6] == 2'b10) return (3 * d + 1) / 2;
        if (m[7:6] == 2'b11) return 2 * d;
        return d;
    endfunction

    function automatic int f_frame(logic [7:0] m);
        return (1 + f_len(m) + int'(m[4])) * f_div(m) + f_stop(m);
    endfunction

    function automatic logic f_bit(logic [7:0] m, logic [7:0] d, int t);
        int   b = t / f_div(m);
        int   n = f_len(m);
        logic p = 1'b0;
        if (b == 0) return 1'b0;
        if (b <= n) return d[b-1];
        if (m[4] && b == n + 1) begin
            for (int i = 0; i < n; i++) p = p ^ d[i];
            return m[5] ? p : ~p;
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] d);
        hold_wr   = 1'b1;
        hold_data = d;
        step();
        hold_wr   = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] m);
        mode_wr   = 1'b1;
        mode_byte = m;
        step();
        mode_wr   = 1'b0;
    endtask

    // Called at frame cycle 0; compares every cycle of the frame
    task automatic watch(input logic [7:0] m, input logic [7:0] d,
                         input int wr_at, input logic [7:0] wr_byte,
                         input int md_at, input logic [7:0] md_byte,
                         input string req);
        int bad = 0;
        int len = f_frame(m);
        int first_t = -1;
        for (int t = 0; t < len; t++) begin
            if (txd !== (f_bit(m, d, t) & ~brk) || shifter_idle !== 1'b0) begin
                bad++;
                if (first_t < 0) first_t = t;
            end
            hold_wr = (t == wr_at);
            if (t == wr_at) hold_data = wr_byte;
            mode_wr = (t == md_at);
            if (t == md_at) mode_byte = md_byte;
            step();
        end
        hold_wr = 1'b0;
        mode_wr = 1'b0;
        check(bad == 0, req, first_t, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] m, d, m2, d2;
        void'($urandom(32'd24680));
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        check(txd === 1'b1, "R1 txd", int'(txd), 1);
        check(hold_empty === 1'b1, "R1 hold_empty", int'(hold_empty), 1);
        check(shifter_idle === 1'b1, "R1 shifter_idle", int'(shifter_idle), 1);

        // R1 R3: default mode sends 5 bits at 1x, upper bits dropped
        tx_enable = 1'b1;
        put(8'hF3);
        check(hold_empty === 1'b0, "R7 held after write", int'(hold_empty), 0);
        check(shifter_idle === 1'b1 && txd === 1'b1, "R8 not yet started", int'(txd), 1);
        step();
        watch(8'h00, 8'hF3, -1, 0, -1, 0, "R1 default frame");
        check(shifter_idle === 1'b1 && txd === 1'b1 && hold_empty === 1'b1,
              "R11 idle after frame", int'(shifter_idle), 1);

        // R2 R3 R6: 16x, 8 bits, no parity, 1 stop
        set_mode(8'h4E);
        put(8'h55);
        step();
        watch(8'h4E, 8'h55, -1, 0, -1, 0, "R2 16x 8N1 frame");

        // R2 R4 R5: 64x, 6 bits, odd parity, 1.5 stop
        set_mode(8'b1001_0111);
        put(8'h2D);
        step();
        watch(8'b1001_0111, 8'h2D, -1, 0, -1, 0, "R5 64x 1.5 stop odd");

        // R8 R12: back-to-back, mode changed mid-frame
        m  = 8'b1011_1001;
        m2 = 8'b1101_1111;
        set_mode(m);
        put(8'hA6);
        step();
        watch(m, 8'hA6, 2, 8'h3C, 3, m2, "R12 first frame old mode");
        watch(m2, 8'h3C, -1, 0, -1, 0, "R8 second frame no gap new mode");
        check(shifter_idle === 1'b1 && hold_empty === 1'b1, "R11 idle after pair",
              int'(shifter_idle), 1);

        // R9 R7: disabled holds, extra write dropped
        tx_enable = 1'b0;
        set_mode(8'h5D);
        put(8'h81);
        put(8'h7E);
        repeat (5) step();
        check(shifter_idle === 1'b1 && txd === 1'b1, "R9 no load while disabled",
              int'(shifter_idle), 1);
        check(hold_empty === 1'b0, "R9 byte kept", int'(hold_empty), 0);
        tx_enable = 1'b1;
        step();
        watch(8'h5D, 8'h81, -1, 0, -1, 0, "R7 first byte kept");
        check(shifter_idle === 1'b1 && hold_empty === 1'b1, "R7 write while full ignored",
              int'(shifter_idle), 1);

        // R9: disable mid-frame, frame completes, pending byte waits
        put(8'hC9);
        step();
        tx_enable = 1'b0;
        watch(8'h5D, 8'hC9, 1, 8'h17, -1, 0, "R9 frame completes");
        step();
        check(shifter_idle === 1'b1 && hold_empty === 1'b0 && txd === 1'b1,
              "R9 pending byte waits", int'(hold_empty), 0);
        tx_enable = 1'b1;
        step();
        watch(8'h5D, 8'h17, -1, 0, -1, 0, "R9 pending byte sent");

        // R10: break idle and during a frame
        brk = 1'b1;
        step();
        check(txd === 1'b0, "R10 break idle", int'(txd), 0);
        put(8'hFF);
        step();
        watch(8'h5D, 8'hFF, -1, 0, -1, 0, "R10 break frame timing");
        check(shifter_idle === 1'b1 && txd === 1'b0, "R10 break still low",
              int'(txd), 0);
        brk = 1'b0;
        step();
        check(txd === 1'b1, "R10 release", int'(txd), 1);

        // R2 R3 R4 R5: random formats
        for (int k = 0; k < 40; k++) begin
            m = 8'($urandom);
            if (k % 4 == 0) m[1:0] = 2'b11;
            d = 8'($urandom);
            set_mode(m);
            put(d);
            step();
            if (k % 3 == 0) begin
                d2 = 8'($urandom);
                watch(m, d, 1, d2, -1, 0, "R4 random first");
                watch(m, d2, -1, 0, -1, 0, "R8 random follow-on");
            end else begin
                watch(m, d, -1, 0, -1, 0, "R3 random frame");
            end
            check(shifter_idle === 1'b1 && txd === 1'b1, "R11 random idle",
                  int'(shifter_idle), 1);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule